// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Guard

This block keeps the 8-bit status byte of a serial flash slave and makes the allow or deny decision for every program and erase request. The command shifter in front of it reports each received opcode, the completion of a status-write data byte, the end of internal operations and the end of an auto-increment sequence. The block answers each request with a one-cycle grant or deny pulse, and it shows the status byte both in parallel and as a serial bit stream for the readout path.

Protection is decided from three protect-code bits, a lock bit and an active-low external protect pin. The lock only holds while the pin is low. The protected range is decoded for a 512 KB array and is always anchored at the top of the array. Status writes must be armed by the opcode that directly precedes them. The write-enable latch is set by one opcode and cleared by a fixed set of events.

Top module: `flash_status_guard`

## Requirements
- R1: After reset the status byte is 8'h1C. Its layout is bit 0 busy, bit 1 write-enable latch, bits 4:2 protect code, bit 5 reserved, bit 6 auto-increment mode and bit 7 lock. Both grant and deny are low.
- R2: A status-write data strobe changes the status byte only when the opcode 01h arrived directly after opcode 06h or opcode 50h. Any other opcode in between disarms the write.
- R3: An armed status write is ignored while the protect pin is low and the lock bit is 1. Otherwise it loads the lock from data bit 7 and the protect code from data bits 4:2 in a single write.
- R4: A status write never changes bits 0, 1 (except the clear in R9), 5 or 6. Bit 5 always reads 0.
- R5: The protect code selects the protected range. 000 protects nothing, 001 protects 70000h–7FFFFh, 010 protects 60000h–7FFFFh, 011 protects 40000h–7FFFFh and 1xx protects the whole array. Only address bits 18:0 are decoded.
- R6: Kinds are encoded on the request: 0 byte program, 1 auto-increment word, 2 sector (4 KB), 3 block (32 KB), 4 block (64 KB) and 5 chip erase. A sector or block erase is denied when any byte of its aligned region lies in the protected range. A word request covers its address and the address with bit 0 set.
- R7: A chip erase is granted only when the protect code is 000.
- R8: A request is denied when the write-enable latch is 0 or busy is 1. Its grant or deny pulse comes one clock after the request strobe, and a grant sets busy.
- R9: Opcode 06h sets the write-enable latch. The latch is cleared by opcode 04h, by every completed status write, and by the completion of any non-auto-increment operation.
- R10: A granted auto-increment request sets bit 6. Its completion clears busy but keeps the latch. While bit 6 is 1, other request kinds are denied. Opcode 04h or the sequence-end strobe clears both bit 6 and the latch.
- R11: The serial output gives the status byte most significant bit first, one bit per advance strobe. It repeats every 8 bits while chip select stays low and restarts at bit 7 when chip select goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wp_n | input | 1 | External protect pin, active low |
| cmd_stb | input | 1 | Opcode received strobe |
| cmd_op | input | 8 | Received opcode |
| sr_wr_stb | input | 1 | Status-write data byte completed (chip select rising) |
| sr_wr_data | input | 8 | Status-write data byte |
| req_stb | input | 1 | Program or erase request strobe |
| req_kind | input | 3 | Request kind (see R6) |
| req_addr | input | 24 | Request target address |
| op_done_stb | input | 1 | Internal operation finished |
| aai_end_stb | input | 1 | Auto-increment sequence ended at top of array |
| cs_n | input | 1 | Chip select, active low |
| so_adv | input | 1 | Advance serial readout by one bit |
| status_o | output | 8 | Status byte |
| so_bit_o | output | 1 | Serial status bit |
| grant_o | output | 1 | Request granted pulse |
| deny_o | output | 1 | Request denied pulse |

## Verification
Every strobe is registered once. The status byte therefore reflects an opcode, status write or completion one clock after its strobe, and the grant or deny pulse for a request likewise appears one clock after the request and lasts one clock. The serial bit depends combinationally on a registered bit pointer, so it is valid before each advance strobe and moves one clock after it. The bench drives every strobe for one cycle starting at a falling edge. It samples at the following falling edge, which is half a period after the registering edge, so each result is read in the one cycle in which it is due.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

    localparam int SR_W = 8;

    typedef enum logic [2:0] {
        OPK_PROG  = 3'd0,
        OPK_AAI   = 3'd1,
        OPK_SECT  = 3'd2,
        OPK_BLK32 = 3'd3,
        OPK_BLK64 = 3'd4,
        OPK_CHIP  = 3'd5
    } op_kind_e;

    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_EWSR = 8'h50;
    localparam logic [7:0] OPC_WRDI = 8'h04;
    localparam logic [7:0] OPC_WRSR = 8'h01;

    typedef struct packed {
        logic       lock;
        logic       aai;
        logic       rsvd;
        logic [2:0] bp;
        logic       wel;
        logic       busy;
    } sr_t;

    localparam sr_t SR_RESET = '{lock: 1'b0, aai: 1'b0, rsvd: 1'b0,
                                 bp: 3'b111, wel: 1'b0, busy: 1'b0};

endpackage

// File: rtl/flash_sr_prot_decode.sv
module flash_sr_prot_decode #(
    parameter int ADDR_W     = 19,
    parameter int SECT_BITS  = 12,
    parameter int BLK32_BITS = 15,
    parameter int BLK64_BITS = 16
) (
    input  logic [2:0]        bp,
    input  logic [2:0]        kind,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    import flash_sr_pkg::*;

    localparam int LOW_W = ADDR_W - 3;

    logic [ADDR_W-1:0] lo_bound;
    logic [ADDR_W-1:0] region_mask;
    logic [ADDR_W-1:0] end_addr;

    always_comb begin
        case (bp)
            3'b001:  lo_bound = {3'b111, {LOW_W{1'b0}}};
            3'b010:  lo_bound = {3'b110, {LOW_W{1'b0}}};
            3'b011:  lo_bound = {3'b100, {LOW_W{1'b0}}};
            default: lo_bound = '0;
        endcase
    end

    always_comb begin
        case (op_kind_e'(kind))
            OPK_PROG:  region_mask = '0;
            OPK_AAI:   region_mask = ADDR_W'(1);
            OPK_SECT:  region_mask = ADDR_W'((1 << SECT_BITS) - 1);
            OPK_BLK32: region_mask = ADDR_W'((1 << BLK32_BITS) - 1);
            OPK_BLK64: region_mask = ADDR_W'((1 << BLK64_BITS) - 1);
            default:   region_mask = '1;
        endcase
        end_addr = addr | region_mask;
        hit      = (bp != 3'b000) && (end_addr >= lo_bound);
    end

endmodule

// File: rtl/flash_sr_readout.sv
module flash_sr_readout #(
    parameter int SR_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            adv,
    input  logic [SR_W-1:0] sr_byte,
    output logic            bit_o
);
    localparam int IDX_W = $clog2(SR_W);

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (cs_n) begin
            idx_d = '0;
        end else if (adv) begin
            idx_d = (idx_q == IDX_W'(SR_W - 1)) ? '0 : idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign bit_o = sr_byte[IDX_W'(SR_W - 1) - idx_q];

endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard #(
    parameter int ADDR_W = 19,
    parameter int HOST_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              cmd_stb,
    input  logic [7:0]        cmd_op,
    input  logic              sr_wr_stb,
    input  logic [7:0]        sr_wr_data,
    input  logic              req_stb,
    input  logic [2:0]        req_kind,
    input  logic [HOST_W-1:0] req_addr,
    input  logic              op_done_stb,
    input  logic              aai_end_stb,
    input  logic              cs_n,
    input  logic              so_adv,
    output logic [7:0]        status_o,
    output logic              so_bit_o,
    output logic              grant_o,
    output logic              deny_o
);
    import flash_sr_pkg::*;

    typedef struct packed {
        sr_t        sr;
        logic       armed;
        logic       wr_ok;
        logic [2:0] act_kind;
        logic       grant;
        logic       deny;
    } guard_t;

    guard_t st_d, st_q;
    logic   prot_hit;
    logic   kind_ok;

    logic addr_hi_unused;
    logic data_unused;
    assign addr_hi_unused = ^req_addr[HOST_W-1:ADDR_W];
    assign data_unused    = ^{sr_wr_data[6:5], sr_wr_data[1:0]};

    flash_sr_prot_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .bp   (st_q.sr.bp),
        .kind (req_kind),
        .addr (req_addr[ADDR_W-1:0]),
        .hit  (prot_hit)
    );

    assign kind_ok = !st_q.sr.aai || (op_kind_e'(req_kind) == OPK_AAI);

    always_comb begin
        st_d       = st_q;
        st_d.grant = 1'b0;
        st_d.deny  = 1'b0;

        if (cmd_stb) begin
            case (cmd_op)
                OPC_WREN: begin
                    st_d.armed  = 1'b1;
                    st_d.wr_ok  = 1'b0;
                    st_d.sr.wel = 1'b1;
                end
                OPC_EWSR: begin
                    st_d.armed = 1'b1;
                    st_d.wr_ok = 1'b0;
                end
                OPC_WRSR: begin
                    st_d.wr_ok = st_q.armed;
                    st_d.armed = 1'b0;
                end
                OPC_WRDI: begin
                    st_d.armed  = 1'b0;
                    st_d.wr_ok  = 1'b0;
                    st_d.sr.wel = 1'b0;
                    st_d.sr.aai = 1'b0;
                end
                default: begin
                    st_d.armed = 1'b0;
                    st_d.wr_ok = 1'b0;
                end
            endcase
        end

        if (sr_wr_stb) begin
            if (st_q.wr_ok && (wp_n || !st_q.sr.lock)) begin
                st_d.sr.lock = sr_wr_data[7];
                st_d.sr.bp   = sr_wr_data[4:2];
            end
            st_d.sr.wel = 1'b0;
            st_d.wr_ok  = 1'b0;
        end

        if (op_done_stb && st_q.sr.busy) begin
            st_d.sr.busy = 1'b0;
            if (op_kind_e'(st_q.act_kind) != OPK_AAI) st_d.sr.wel = 1'b0;
        end

        if (aai_end_stb) begin
            st_d.sr.aai = 1'b0;
            st_d.sr.wel = 1'b0;
        end

        if (req_stb) begin
            if (st_q.sr.wel && !st_q.sr.busy && !prot_hit && kind_ok) begin
                st_d.grant    = 1'b1;
                st_d.sr.busy  = 1'b1;
                st_d.act_kind = req_kind;
                if (op_kind_e'(req_kind) == OPK_AAI) st_d.sr.aai = 1'b1;
            end else begin
                st_d.deny = 1'b1;
            end
        end

        st_d.sr.rsvd = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sr       <= SR_RESET;
            st_q.armed    <= 1'b0;
            st_q.wr_ok    <= 1'b0;
            st_q.act_kind <= '0;
            st_q.grant    <= 1'b0;
            st_q.deny     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    flash_sr_readout #(
        .SR_W (SR_W)
    ) u_readout (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .adv     (so_adv),
        .sr_byte (status_o),
        .bit_o   (so_bit_o)
    );

    assign status_o = st_q.sr;
    assign grant_o  = st_q.grant;
    assign deny_o   = st_q.deny;

endmodule

// File: rtl/flash_status_guard_chk.sv
module flash_status_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_n,
    input logic       sr_wr_stb,
    input logic       req_stb,
    input logic [2:0] req_kind,
    input logic [7:0] status_o,
    input logic       grant_o,
    input logic       deny_o
);
    assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[5] == 1'b0);

    assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && deny_o));

    assert_grant_needs_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> ($past(req_stb) && $past(status_o[1]) && !$past(status_o[0])));

    assert_answer_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_stb |=> (grant_o || deny_o));

    assert_locked_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && status_o[7] && sr_wr_stb) |=> (status_o[7:2] == $past(status_o[7:2])));

    assert_chip_unprot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && $past(req_kind) == 3'd5) |-> ($past(status_o[4:2]) == 3'b000));

    assert_busy_on_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> status_o[0]);

endmodule

bind flash_status_guard flash_status_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wp_n      (wp_n),
    .sr_wr_stb (sr_wr_stb),
    .req_stb   (req_stb),
    .req_kind  (req_kind),
    .status_o  (status_o),
    .grant_o   (grant_o),
    .deny_o    (deny_o)
);

// File: tb/flash_status_guard_bench.sv
module flash_status_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wp_n = 1'b1;
    logic        cmd_stb = 1'b0;
    logic [7:0]  cmd_op = '0;
    logic        sr_wr_stb = 1'b0;
    logic [7:0]  sr_wr_data = '0;
    logic        req_stb = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [23:0] req_addr = '0;
    logic        op_done_stb = 1'b0;
    logic        aai_end_stb = 1'b0;
    logic        cs_n = 1'b1;
    logic        so_adv = 1'b0;
    logic [7:0]  status_o;
    logic        so_bit_o;
    logic        grant_o;
    logic        deny_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    flash_status_guard u_flash_status_guard (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
        .cmd_stb(cmd_stb), .cmd_op(cmd_op),
        .sr_wr_stb(sr_wr_stb), .sr_wr_data(sr_wr_data),
        .req_stb(req_stb), .req_kind(req_kind), .req_addr(req_addr),
        .op_done_stb(op_done_stb), .aai_end_stb(aai_end_stb),
        .cs_n(cs_n), .so_adv(so_adv),
        .status_o(status_o), .so_bit_o(so_bit_o),
        .grant_o(grant_o), .deny_o(deny_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [7:0] op);
        @(negedge clk); cmd_stb = 1'b1; cmd_op = op;
        @(negedge clk); cmd_stb = 1'b0;
    endtask

    task automatic srw(input logic [7:0] d);
        @(negedge clk); sr_wr_stb = 1'b1; sr_wr_data = d;
        @(negedge clk); sr_wr_stb = 1'b0;
    endtask

    task automatic req(input logic [2:0] k, input logic [23:0] a);
        @(negedge clk); req_stb = 1'b1; req_kind = k; req_addr = a;
        @(negedge clk); req_stb = 1'b0;
    endtask

    task automatic opdone();
        @(negedge clk); op_done_stb = 1'b1;
        @(negedge clk); op_done_stb = 1'b0;
    endtask

    task automatic set_sr(input logic [7:0] d);
        cmd(8'h50); cmd(8'h01); srw(d);
    endtask

    function automatic bit exp_grant(input logic [2:0] bp, input logic [2:0] k,
                                     input logic [23:0] a);
        logic [18:0] last;
        logic [18:0] lo;
        case (k)
            3'd0: last = a[18:0];
            3'd1: last = a[18:0] | 19'h1;
            3'd2: last = a[18:0] | 19'hFFF;
            3'd3: last = a[18:0] | 19'h7FFF;
            3'd4: last = a[18:0] | 19'hFFFF;
            default: last = 19'h7FFFF;
        endcase
        case (bp)
            3'b000: return 1'b1;
            3'b001: lo = 19'h70000;
            3'b010: lo = 19'h60000;
            3'b011: lo = 19'h40000;
            default: lo = 19'h00000;
        endcase
        return last < lo;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset status", status_o, 8'h1C);
        check("R1 reset pulses", {grant_o, deny_o}, 2'b00);

        // R11 serial readout, two rounds then restart
        cs_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            check("R11 serial bit", so_bit_o, status_o[7 - (i % 8)]);
            so_adv = 1'b1; @(negedge clk); so_adv = 1'b0;
        end
        so_adv = 1'b1; @(negedge clk); so_adv = 1'b0;
        cs_n = 1'b1; @(negedge clk); cs_n = 1'b0; @(negedge clk);
        check("R11 restart at msb", so_bit_o, status_o[7]);
        cs_n = 1'b1;

        // R8 no write-enable latch
        req(3'd0, 24'h000100);
        check("R8 deny without latch", {grant_o, deny_o}, 2'b01);
        check("R8 busy stays clear", status_o[0], 1'b0);

        // R2 unarmed write, armed write, disarmed by other opcode
        cmd(8'h01); srw(8'h00);
        check("R2 unarmed write ignored", status_o, 8'h1C);
        set_sr(8'h00);
        check("R2 armed write applied", status_o, 8'h00);
        cmd(8'h06); cmd(8'h05); cmd(8'h01); srw(8'h0C);
        check("R2 disarmed write ignored, R9 latch cleared", status_o, 8'h00);

        // R9 set and clear of latch
        cmd(8'h06);
        check("R9 latch set", status_o, 8'h02);
        cmd(8'h04);
        check("R9 latch cleared by 04h", status_o, 8'h00);

        // R3 / R4 lock behaviour
        wp_n = 1'b0;
        set_sr(8'hFF);
        check("R3 lock and code set together, R4 bits kept", status_o, 8'h9C);
        set_sr(8'h00);
        check("R3 locked write ignored", status_o, 8'h9C);
        wp_n = 1'b1;
        set_sr(8'h00);
        check("R3 pin high allows write", status_o, 8'h00);

        // R5 / R6 / R7 directed ranges with code 001
        set_sr(8'h04);
        cmd(8'h06); req(3'd0, 24'h06FFFF);
        check("R5 below range granted", grant_o, 1'b1);
        opdone();
        check("R9 latch cleared on completion", status_o, 8'h04);
        cmd(8'h06); req(3'd0, 24'h070000);
        check("R5 in range denied", deny_o, 1'b1);
        req(3'd3, 24'h078000);
        check("R6 block in range denied", deny_o, 1'b1);
        req(3'd4, 24'h068000);
        check("R6 aligned block below range granted", grant_o, 1'b1);
        req(3'd2, 24'h000000);
        check("R8 busy denies request", deny_o, 1'b1);
        opdone();
        cmd(8'h06); req(3'd5, 24'h0);
        check("R7 chip erase denied with code 001", deny_o, 1'b1);
        cmd(8'h04);
        set_sr(8'h00);
        cmd(8'h06); req(3'd5, 24'h0);
        check("R7 chip erase granted with code 000", grant_o, 1'b1);
        opdone();

        // R10 auto-increment sequence
        cmd(8'h06); req(3'd1, 24'h000100);
        check("R10 mode and busy set", status_o, 8'h43);
        opdone();
        check("R10 latch kept after word", status_o, 8'h42);
        req(3'd2, 24'h000000);
        check("R10 other kind denied in mode", deny_o, 1'b1);
        req(3'd1, 24'h000102);
        check("R10 next word granted", grant_o, 1'b1);
        opdone();
        @(negedge clk); aai_end_stb = 1'b1; @(negedge clk); aai_end_stb = 1'b0;
        check("R10 end strobe clears mode and latch", status_o, 8'h00);
        cmd(8'h06); req(3'd1, 24'h000200); opdone(); cmd(8'h04);
        check("R10 04h exits mode", status_o, 8'h00);

        // R5 R6 R7 random protection sweep
        for (int it = 0; it < 80; it++) begin
            logic [2:0]  code;
            logic [2:0]  k;
            logic [23:0] a;
            bit          eg;
            code = 3'($urandom % 8);
            k    = 3'($urandom % 6);
            a    = 24'($urandom);
            set_sr({3'b000, code, 2'b00});
            check("R5 code loaded", status_o, {3'b000, code, 2'b00});
            eg = exp_grant(code, k, a);
            cmd(8'h06); req(k, a);
            check("R6 random decision", {grant_o, deny_o}, {eg, !eg});
            if (eg) opdone();
            cmd(8'h04);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule